// File: doc/BRIEF.md
# Nine-bit UART receiver with address filtering

This block deserialises asynchronous frames from a single serial line. A frame opens with a low start bit, carries 8 data bits, or 9 when the nine-bit mode is selected, with the least significant bit first, and closes with one stop bit. The line is sampled on an external oversampling tick that runs at 16 times the bit rate. Each bit value is taken as the majority of three samples around the middle of the bit.

In nine-bit mode, an address-wait control lets a node on a shared multidrop line ignore traffic meant for other nodes. While the control is set, a frame is accepted only if its ninth bit is 1 and its byte matches a programmed address. The match skips every bit position whose mask bit is 0. Software clears the control once its own address has arrived, so that the data bytes that follow are taken. It sets the control again to wait for the next address.

Accepted frames raise a completion flag that stays set until software clears it. Framing, break and overrun conditions are held in sticky status flags.

Top module: `uart9_rx`

## Requirements
- R1: In 8-bit mode (mode_nine=0), the 8 bits after the start bit are assembled LSB first into rx_byte, rx_bit9 reads 0, and rx_done is set.
- R2: In nine-bit mode (mode_nine=1), a ninth data bit follows the eight data bits and is presented on rx_bit9 together with rx_byte.
- R3: Each bit is the majority of oversamples 7, 8 and 9 of 0..15, so one corrupted sample inside that window does not change the received value.
- R4: A falling edge whose start bit reads 1 at mid-bit is rejected as noise. No completion or error flag changes, and the next proper frame is received normally.
- R5: While rx_en is 0, no new frame is started and the outputs stay unchanged.
- R6: With mode_nine=1 and addr_wait=1, a frame completes only if its ninth bit is 1 and ((byte XOR my_addr) AND addr_mask) is 0. Other frames leave rx_done, rx_byte and rx_bit9 unchanged.
- R7: With addr_wait=0, or in 8-bit mode, every frame is accepted whatever its address.
- R8: A stop bit sampled as 0 sets frame_err.
- R9: When the start bit, every data bit and the stop bit are all 0, brk_err is set along with frame_err.
- R10: When an accepted frame completes while rx_done is still set, ovr_err is set, and rx_byte and rx_bit9 keep the earlier frame.
- R11: After reset all outputs are 0. A pulse on clr_done clears rx_done, and a pulse on clr_stat clears frame_err, brk_err and ovr_err.
- R12: rx_done stays set until clr_done is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| mode_nine | input | 1 | 1: nine data bits per frame, 0: eight |
| rx_en | input | 1 | Allows new frames to start |
| addr_wait | input | 1 | Accept only matching address frames (nine-bit mode) |
| my_addr | input | 8 | Programmed node address |
| addr_mask | input | 8 | 1 = address bit compared, 0 = don't care |
| clr_done | input | 1 | Clears rx_done |
| clr_stat | input | 1 | Clears the error flags |
| rx_byte | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_done | output | 1 | Receive-complete flag |
| frame_err | output | 1 | Stop bit read as 0 |
| brk_err | output | 1 | All-zero frame seen |
| ovr_err | output | 1 | Frame accepted while rx_done was set |

## Verification
All 256 byte values are sent in 8-bit mode. All 256 are sent again in nine-bit mode with a ninth bit that varies between frames, which separates correct bit ordering from swapped or dropped positions. A further sweep of all 256 bytes runs with address-wait set, a partial mask and the ninth bit high. Exactly the sixteen masked matches must complete, which separates a masked compare from a full compare or no compare. Single frames then cover a one-sample glitch, a false start, a disabled receiver, a ninth bit of 0 on a matching byte, a zero stop bit, an all-zero frame and a second frame arriving before the first is cleared.

// File: rtl/uart9_rx.sv
module uart9_rx #(
  parameter int OS_RATE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       mode_nine,
  input  logic       rx_en,
  input  logic       addr_wait,
  input  logic [7:0] my_addr,
  input  logic [7:0] addr_mask,
  input  logic       clr_done,
  input  logic       clr_stat,
  output logic [7:0] rx_byte,
  output logic       rx_bit9,
  output logic       rx_done,
  output logic       frame_err,
  output logic       brk_err,
  output logic       ovr_err
);
  localparam int CW  = $clog2(OS_RATE);
  localparam int MID = OS_RATE / 2;

  logic [1:0]    sync;
  logic          busy, armed, nine_q, s_a, s_b, all_zero;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [8:0]    sh;

  wire rxs      = sync[1];
  wire start_ok = os_tick && !busy && armed && !rxs && rx_en;
  wire decide   = os_tick && busy && (cnt == CW'(MID + 1));
  wire bitv     = (s_a & s_b) | (s_a & rxs) | (s_b & rxs);
  wire [3:0] last = nine_q ? 4'd10 : 4'd9;
  wire fin      = decide && (idx == last);
  wire [7:0] got  = nine_q ? sh[7:0] : sh[8:1];
  wire got9     = nine_q & sh[8];
  wire match    = ((got ^ my_addr) & addr_mask) == 8'd0;
  wire accept   = !(nine_q && addr_wait) || (got9 && match);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                armed <= 1'b0;
    else if (os_tick && !busy) armed <= rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; idx <= '0; nine_q <= 1'b0;
      s_a <= 1'b0; s_b <= 1'b0; all_zero <= 1'b0; sh <= '0;
    end else if (start_ok) begin
      busy <= 1'b1; cnt <= CW'(1); idx <= '0;
      nine_q <= mode_nine; all_zero <= 1'b1;
    end else if (busy && os_tick) begin
      cnt <= (cnt == CW'(OS_RATE - 1)) ? '0 : cnt + 1'b1;
      if (cnt == CW'(OS_RATE - 1)) idx <= idx + 1'b1;
      if (cnt == CW'(MID - 1)) s_a <= rxs;
      if (cnt == CW'(MID))     s_b <= rxs;
      if (decide) begin
        all_zero <= all_zero & ~bitv;
        if (idx == 4'd0) begin
          if (bitv) busy <= 1'b0;
        end else if (fin) begin
          busy <= 1'b0;
        end else begin
          sh <= {bitv, sh[8:1]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0; rx_bit9 <= 1'b0; rx_done <= 1'b0;
      frame_err <= 1'b0; brk_err <= 1'b0; ovr_err <= 1'b0;
    end else begin
      if (clr_done) rx_done <= 1'b0;
      if (clr_stat) begin
        frame_err <= 1'b0; brk_err <= 1'b0; ovr_err <= 1'b0;
      end
      if (fin) begin
        if (!bitv)             frame_err <= 1'b1;
        if (!bitv && all_zero) brk_err   <= 1'b1;
        if (accept) begin
          if (rx_done && !clr_done) begin
            ovr_err <= 1'b1;
          end else begin
            rx_byte <= got; rx_bit9 <= got9; rx_done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart9_rx_chk.sv
module uart9_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       addr_wait,
  input logic       mode_nine,
  input logic       clr_done,
  input logic       busy,
  input logic       fin,
  input logic [7:0] rx_byte,
  input logic       rx_bit9,
  input logic       rx_done,
  input logic       frame_err,
  input logic       brk_err
);
  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !clr_done) |=> rx_done);
  // R10
  byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !clr_done) |=> ($stable(rx_byte) && $stable(rx_bit9)));
  // R11
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !fin) |=> !rx_done);
  // R9
  brk_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_err) |-> frame_err);
  // R5
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rx_en) |=> !busy);
  // R6
  addr_bit9_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_done) && $past(addr_wait) && $past(mode_nine)) |-> rx_bit9);
endmodule

bind uart9_rx uart9_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .addr_wait(addr_wait),
  .mode_nine(mode_nine), .clr_done(clr_done), .busy(busy), .fin(fin),
  .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_done(rx_done),
  .frame_err(frame_err), .brk_err(brk_err)
);

// File: tb/sim_uart9_rx.sv
module sim_uart9_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd = 1'b1, mode_nine = 1'b0, rx_en = 1'b1, addr_wait = 1'b0;
  logic clr_done = 1'b0, clr_stat = 1'b0;
  logic [7:0] my_addr = 8'hA5, addr_mask = 8'hF0;
  logic [7:0] rx_byte;
  logic rx_bit9, rx_done, frame_err, brk_err, ovr_err;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  uart9_rx u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(1'b1), .rxd(rxd), .mode_nine(mode_nine),
    .rx_en(rx_en), .addr_wait(addr_wait), .my_addr(my_addr), .addr_mask(addr_mask),
    .clr_done(clr_done), .clr_stat(clr_stat), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
    .rx_done(rx_done), .frame_err(frame_err), .brk_err(brk_err), .ovr_err(ovr_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input bit glitch);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      rxd = (glitch && k == 8) ? ~v : v;
    end
  endtask

  task automatic send(input bit nine, input logic [8:0] d, input logic stopv, input int gbit);
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) drive_bit(d[i], gbit == i);
    drive_bit(stopv, 1'b0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rxd = 1'b1;
    end
  endtask

  task automatic pulse_clr(input bit d, input bit s);
    @(negedge clk);
    clr_done = d; clr_stat = s;
    @(negedge clk);
    clr_done = 1'b0; clr_stat = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] last_ok;
    repeat (3) @(negedge clk);
    chk("R11 reset done", rx_done, 0);
    chk("R11 reset flags", {frame_err, brk_err, ovr_err}, 0);
    chk("R11 reset byte", {rx_bit9, rx_byte}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R7: eight-bit sweep, addr_wait set but ignored in this mode
    addr_wait = 1'b1;
    for (int b = 0; b < 256; b++) begin
      send(1'b0, {1'b0, 8'(b)}, 1'b1, -1);
      chk("R1 done", rx_done, 1);
      chk("R1 byte", rx_byte, b);
      chk("R1 bit9", rx_bit9, 0);
      pulse_clr(1'b1, 1'b0);
    end
    chk("R11 done cleared", rx_done, 0);
    chk("R1 no errors", {frame_err, brk_err, ovr_err}, 0);

    // R2 R7: nine-bit sweep without address wait
    mode_nine = 1'b1; addr_wait = 1'b0;
    for (int b = 0; b < 256; b++) begin
      logic n9;
      n9 = b[0] ^ b[7] ^ b[3];
      send(1'b1, {n9, 8'(b)}, 1'b1, -1);
      chk("R2 done", rx_done, 1);
      chk("R2 byte", rx_byte, b);
      chk("R2 bit9", rx_bit9, n9);
      pulse_clr(1'b1, 1'b0);
    end

    // R6: address filter sweep, mask F0, address A5
    addr_wait = 1'b1;
    last_ok = rx_byte;
    for (int b = 0; b < 256; b++) begin
      bit hit;
      hit = ((8'(b) ^ my_addr) & addr_mask) == 8'd0;
      send(1'b1, {1'b1, 8'(b)}, 1'b1, -1);
      if (hit) last_ok = 8'(b);
      chk("R6 done", rx_done, hit);
      chk("R6 byte", rx_byte, last_ok);
      pulse_clr(1'b1, 1'b0);
    end
    // R6: ninth bit 0 on an exact address is rejected
    send(1'b1, {1'b0, 8'hA5}, 1'b1, -1);
    chk("R6 bit9 low reject", rx_done, 0);
    chk("R6 byte kept", rx_byte, last_ok);
    addr_wait = 1'b0;
    mode_nine = 1'b0;

    // R3: one wrong sample in the middle of data bit 3
    send(1'b0, 9'h0A5, 1'b1, 3);
    chk("R3 glitch done", rx_done, 1);
    chk("R3 glitch byte", rx_byte, 8'hA5);
    pulse_clr(1'b1, 1'b0);

    // R4: false start
    for (int k = 0; k < 4; k++) begin @(negedge clk); rxd = 1'b0; end
    for (int k = 0; k < 40; k++) begin @(negedge clk); rxd = 1'b1; end
    chk("R4 no done", rx_done, 0);
    chk("R4 no flags", {frame_err, brk_err, ovr_err}, 0);
    send(1'b0, 9'h03C, 1'b1, -1);
    chk("R4 next frame", rx_byte, 8'h3C);
    pulse_clr(1'b1, 1'b0);

    // R5: receiver disabled
    rx_en = 1'b0;
    send(1'b0, 9'h0C3, 1'b1, -1);
    chk("R5 no done", rx_done, 0);
    chk("R5 byte kept", rx_byte, 8'h3C);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R8: zero stop bit
    send(1'b0, 9'h055, 1'b0, -1);
    chk("R8 frame_err", frame_err, 1);
    chk("R8 no break", brk_err, 0);
    pulse_clr(1'b1, 1'b1);
    chk("R11 flags cleared", frame_err, 0);

    // R9: all-zero frame
    send(1'b0, 9'h000, 1'b0, -1);
    chk("R9 brk_err", brk_err, 1);
    chk("R9 frame_err", frame_err, 1);
    pulse_clr(1'b1, 1'b1);

    // R10 R12: second frame before clear
    send(1'b0, 9'h011, 1'b1, -1);
    send(1'b0, 9'h022, 1'b1, -1);
    chk("R12 done held", rx_done, 1);
    chk("R10 ovr_err", ovr_err, 1);
    chk("R10 old byte", rx_byte, 8'h11);
    pulse_clr(1'b1, 1'b1);
    chk("R11 ovr cleared", ovr_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule